// File: doc/BRIEF.md
# Window-Constrained Stream State Updater

This block holds the scheduling state of every stream served by a window-constrained real-time packet scheduler. Each stream carries a current deadline, an inter-packet gap, a configured loss tolerance (at most x late or lost packets in every window of y), a working copy of that tolerance, a droppable flag and an active flag. An external selector reports which stream it has just serviced. The block then moves that stream's deadline forward by one gap and narrows its working window.

On a time tick the block walks the stream table in index order, one stream per clock. A stream whose deadline lies in the past gets one miss pass per cycle. Each pass charges the loss tolerance, asks for the head packet to be dropped if the stream allows drops, and moves the deadline forward by one gap. The block repeats passes on the same stream until its deadline is no longer behind the tick time. Deadlines use 16-bit wrap-around arithmetic. A read port exposes any stream's deadline and working tolerance.

Top module: `streamWindowUpdater`

## Requirements
- R1: After reset every stream is inactive, with deadline, working x and working y all zero, and busy, dropValid and violValid are low.
- R2: A configuration write to stream i loads its deadline, gap, configured x and y, and droppable flag. It sets working x and y to the configured values and marks the stream active.
- R3: A service event on stream i adds its gap to its deadline, modulo 2^16.
- R4: On a service, when working y is greater than working x, working y drops by one. If that makes it zero, working x and y reload from the configuration. Otherwise the tolerance is unchanged.
- R5: During a scan, an active stream is missed when (tickTime - deadline) mod 2^16, read as a signed 16-bit value, is strictly positive. A deadline equal to the tick time is not missed.
- R6: A missed stream receives one pass per cycle, and each pass adds the gap to the deadline. Passes repeat until the stream is no longer missed, and only then does the scan move to the next index.
- R7: On a pass with working x greater than zero, working x and y each drop by one (y saturating at zero). When working x reaches zero, both reload from the configuration.
- R8: On a pass with working x equal to zero, violValid pulses with violIdx set to the stream and the working tolerance stays unchanged.
- R9: A pass on a droppable stream pulses dropValid with dropIdx set to the stream, one cycle after the pass. A pass on a stream that is not droppable gives no drop pulse.
- R10: A tick while idle latches tickTime and raises busy on the next cycle. Streams are visited in increasing index order, at most one stream update per cycle, and busy falls after the last index.
- R11: A tick that arrives while busy is high is ignored.
- R12: A configuration write or a service event in the same cycle as a scan step takes priority, and the scan holds for that cycle. Inactive streams are never missed.
- R13: A gap of zero advances the deadline by one on a miss pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgIdx | input | 6 | Stream written |
| cfgDeadline | input | 16 | Initial deadline |
| cfgGap | input | 16 | Inter-packet gap |
| cfgX | input | 5 | Allowed late packets per window |
| cfgY | input | 5 | Window length |
| cfgDrop | input | 1 | Head packet may be dropped when late |
| svcValid | input | 1 | Service event strobe |
| svcIdx | input | 6 | Serviced stream |
| tickValid | input | 1 | Time tick strobe |
| tickTime | input | 16 | Current time for the tick |
| rdIdx | input | 6 | Stream read |
| rdDeadline | output | 16 | Deadline of stream rdIdx |
| rdCurX | output | 5 | Working x of stream rdIdx |
| rdCurY | output | 5 | Working y of stream rdIdx |
| busy | output | 1 | Scan in progress |
| dropValid | output | 1 | Drop request pulse |
| dropIdx | output | 6 | Stream whose head packet is dropped |
| violValid | output | 1 | Constraint violation pulse |
| violIdx | output | 6 | Stream in violation |

## Verification
Configuration and service updates appear on the combinational read port in the cycle after their strobe. The bench therefore reads state only at a falling edge after the strobe has been sampled. A tick raises busy one cycle later, which the bench checks at the next falling edge. Drop and violation pulses come one cycle after each pass. They are tallied per stream by a falling-edge monitor, and the bench compares the tallies only after busy has fallen and two further cycles have passed. The priority and ignored-tick cases issue their stimulus while busy is high, then check the resulting deadlines through the read port once the scan has finished.

// File: rtl/wcsPkg.sv
package wcsPkg;
  localparam int WCS_STREAMS = 64;
  localparam int WCS_TIME_W  = 16;
  localparam int WCS_TOL_W   = 5;

  typedef struct packed {
    logic doCfg;
    logic doSvc;
    logic doMiss;
  } wcsOps_t;

  typedef enum logic {ST_IDLE, ST_SCAN} wcsState_e;
endpackage

// File: rtl/wcsCtrl.sv
module wcsCtrl
  import wcsPkg::*;
#(
  parameter int NumStreams = WCS_STREAMS,
  parameter int TimeW      = WCS_TIME_W,
  localparam int IdxW      = $clog2(NumStreams)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWe,
  input  logic [IdxW-1:0] cfgIdx,
  input  logic            svcValid,
  input  logic [IdxW-1:0] svcIdx,
  input  logic            tickValid,
  input  logic [TimeW-1:0] tickTime,
  input  logic            probeMissed,
  output wcsOps_t         ops,
  output logic [IdxW-1:0] opIdx,
  output logic [IdxW-1:0] probeIdx,
  output logic [TimeW-1:0] probeNow,
  output logic            busy
);
  localparam logic [IdxW-1:0] LastIdx = IdxW'(NumStreams - 1);

  wcsState_e state;
  logic [IdxW-1:0] scanIdx;
  logic [TimeW-1:0] nowQ;

  assign probeIdx = scanIdx;
  assign probeNow = nowQ;
  assign busy     = (state == ST_SCAN);

  // Configuration beats service, service beats a scan pass.
  always_comb begin
    ops   = '0;
    opIdx = scanIdx;
    if (cfgWe) begin
      ops.doCfg = 1'b1;
      opIdx     = cfgIdx;
    end else if (svcValid) begin
      ops.doSvc = 1'b1;
      opIdx     = svcIdx;
    end else if (state == ST_SCAN && probeMissed) begin
      ops.doMiss = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      scanIdx <= '0;
      nowQ    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (tickValid) begin
            nowQ    <= tickTime;
            scanIdx <= '0;
            state   <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (!cfgWe && !svcValid && !probeMissed) begin
            if (scanIdx == LastIdx) state <= ST_IDLE;
            else scanIdx <= scanIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R12: never more than one stream update per cycle
  a_r12_single_op: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ops.doCfg, ops.doSvc, ops.doMiss}));

  // R6: miss passes only happen inside a scan
  a_r6_miss_in_scan: assert property (@(posedge clk) disable iff (!rstN)
    ops.doMiss |-> busy);

  // R10: scan index holds or steps by one
  a_r10_index_step: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (scanIdx == $past(scanIdx) || scanIdx == $past(scanIdx) + 1'b1));

  // R11: latched time stays fixed for a whole scan
  a_r11_time_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(nowQ));
endmodule

// File: rtl/wcsDatapath.sv
module wcsDatapath
  import wcsPkg::*;
#(
  parameter int NumStreams = WCS_STREAMS,
  parameter int TimeW      = WCS_TIME_W,
  parameter int TolW       = WCS_TOL_W,
  localparam int IdxW      = $clog2(NumStreams)
) (
  input  logic             clk,
  input  logic             rstN,
  input  wcsOps_t          ops,
  input  logic [IdxW-1:0]  opIdx,
  input  logic [TimeW-1:0] cfgDeadline,
  input  logic [TimeW-1:0] cfgGap,
  input  logic [TolW-1:0]  cfgX,
  input  logic [TolW-1:0]  cfgY,
  input  logic             cfgDrop,
  input  logic [IdxW-1:0]  probeIdx,
  input  logic [TimeW-1:0] probeNow,
  output logic             probeMissed,
  input  logic [IdxW-1:0]  rdIdx,
  output logic [TimeW-1:0] rdDeadline,
  output logic [TolW-1:0]  rdCurX,
  output logic [TolW-1:0]  rdCurY,
  output logic             dropValid,
  output logic [IdxW-1:0]  dropIdx,
  output logic             violValid,
  output logic [IdxW-1:0]  violIdx
);
  logic [TimeW-1:0] deadline [NumStreams];
  logic [TimeW-1:0] gap      [NumStreams];
  logic [TolW-1:0]  limX     [NumStreams];
  logic [TolW-1:0]  limY     [NumStreams];
  logic [TolW-1:0]  curX     [NumStreams];
  logic [TolW-1:0]  curY     [NumStreams];
  logic             dropOk   [NumStreams];
  logic             active   [NumStreams];

  // Wrap-safe lateness test on the scanned stream
  logic [TimeW-1:0] lag;
  always_comb begin
    lag         = probeNow - deadline[probeIdx];
    probeMissed = active[probeIdx] && !lag[TimeW-1] && (lag != '0);
  end

  assign rdDeadline = deadline[rdIdx];
  assign rdCurX     = curX[rdIdx];
  assign rdCurY     = curY[rdIdx];

  // Next tolerance after a service
  logic [TolW-1:0] svcX, svcY;
  always_comb begin
    svcX = curX[opIdx];
    svcY = curY[opIdx];
    if (curY[opIdx] > curX[opIdx]) begin
      svcY = curY[opIdx] - 1'b1;
      if (svcY == '0) begin
        svcX = limX[opIdx];
        svcY = limY[opIdx];
      end
    end
  end

  // Next tolerance and deadline step after a miss pass
  logic [TolW-1:0]  missX, missY;
  logic             missViol;
  logic [TimeW-1:0] missStep;
  always_comb begin
    missX    = curX[opIdx];
    missY    = curY[opIdx];
    missViol = 1'b0;
    if (curX[opIdx] != '0) begin
      missX = curX[opIdx] - 1'b1;
      missY = (curY[opIdx] != '0) ? curY[opIdx] - 1'b1 : '0;
      if (missX == '0) begin
        missX = limX[opIdx];
        missY = limY[opIdx];
      end
    end else begin
      missViol = 1'b1;
    end
    missStep = (gap[opIdx] == '0) ? TimeW'(1) : gap[opIdx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NumStreams; i++) begin
        deadline[i] <= '0;
        gap[i]      <= '0;
        limX[i]     <= '0;
        limY[i]     <= '0;
        curX[i]     <= '0;
        curY[i]     <= '0;
        dropOk[i]   <= 1'b0;
        active[i]   <= 1'b0;
      end
    end else if (ops.doCfg) begin
      deadline[opIdx] <= cfgDeadline;
      gap[opIdx]      <= cfgGap;
      limX[opIdx]     <= cfgX;
      limY[opIdx]     <= cfgY;
      curX[opIdx]     <= cfgX;
      curY[opIdx]     <= cfgY;
      dropOk[opIdx]   <= cfgDrop;
      active[opIdx]   <= 1'b1;
    end else if (ops.doSvc) begin
      deadline[opIdx] <= deadline[opIdx] + gap[opIdx];
      curX[opIdx]     <= svcX;
      curY[opIdx]     <= svcY;
    end else if (ops.doMiss) begin
      deadline[opIdx] <= deadline[opIdx] + missStep;
      curX[opIdx]     <= missX;
      curY[opIdx]     <= missY;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dropValid <= 1'b0;
      dropIdx   <= '0;
      violValid <= 1'b0;
      violIdx   <= '0;
    end else begin
      dropValid <= ops.doMiss && dropOk[opIdx];
      dropIdx   <= opIdx;
      violValid <= ops.doMiss && missViol;
      violIdx   <= opIdx;
    end
  end

  // R5: a pass is only issued on the stream the probe flagged late
  a_r5_miss_from_probe: assert property (@(posedge clk) disable iff (!rstN)
    ops.doMiss |-> (probeMissed && opIdx == probeIdx));

  // R12: an inactive stream is never charged a miss
  a_r12_inactive_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ops.doMiss |-> active[opIdx]);
endmodule

// File: rtl/streamWindowUpdater.sv
module streamWindowUpdater
  import wcsPkg::*;
#(
  parameter int NumStreams = WCS_STREAMS,
  parameter int TimeW      = WCS_TIME_W,
  parameter int TolW       = WCS_TOL_W,
  localparam int IdxW      = $clog2(NumStreams)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [IdxW-1:0]  cfgIdx,
  input  logic [TimeW-1:0] cfgDeadline,
  input  logic [TimeW-1:0] cfgGap,
  input  logic [TolW-1:0]  cfgX,
  input  logic [TolW-1:0]  cfgY,
  input  logic             cfgDrop,
  input  logic             svcValid,
  input  logic [IdxW-1:0]  svcIdx,
  input  logic             tickValid,
  input  logic [TimeW-1:0] tickTime,
  input  logic [IdxW-1:0]  rdIdx,
  output logic [TimeW-1:0] rdDeadline,
  output logic [TolW-1:0]  rdCurX,
  output logic [TolW-1:0]  rdCurY,
  output logic             busy,
  output logic             dropValid,
  output logic [IdxW-1:0]  dropIdx,
  output logic             violValid,
  output logic [IdxW-1:0]  violIdx
);
  wcsOps_t          ops;
  logic [IdxW-1:0]  opIdx;
  logic [IdxW-1:0]  probeIdx;
  logic [TimeW-1:0] probeNow;
  logic             probeMissed;

  wcsCtrl #(.NumStreams(NumStreams), .TimeW(TimeW)) ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx),
    .svcValid(svcValid), .svcIdx(svcIdx),
    .tickValid(tickValid), .tickTime(tickTime),
    .probeMissed(probeMissed),
    .ops(ops), .opIdx(opIdx),
    .probeIdx(probeIdx), .probeNow(probeNow),
    .busy(busy)
  );

  wcsDatapath #(.NumStreams(NumStreams), .TimeW(TimeW), .TolW(TolW)) dp (
    .clk(clk), .rstN(rstN),
    .ops(ops), .opIdx(opIdx),
    .cfgDeadline(cfgDeadline), .cfgGap(cfgGap),
    .cfgX(cfgX), .cfgY(cfgY), .cfgDrop(cfgDrop),
    .probeIdx(probeIdx), .probeNow(probeNow), .probeMissed(probeMissed),
    .rdIdx(rdIdx), .rdDeadline(rdDeadline), .rdCurX(rdCurX), .rdCurY(rdCurY),
    .dropValid(dropValid), .dropIdx(dropIdx),
    .violValid(violValid), .violIdx(violIdx)
  );
endmodule

// File: tb/streamWindowUpdater_test.sv
`timescale 1ns/1ps
module streamWindowUpdater_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 0, cfgDrop = 0, svcValid = 0, tickValid = 0;
  logic [5:0] cfgIdx = 0, svcIdx = 0, rdIdx = 0;
  logic [15:0] cfgDeadline = 0, cfgGap = 0, tickTime = 0;
  logic [4:0] cfgX = 0, cfgY = 0;
  logic [15:0] rdDeadline;
  logic [4:0] rdCurX, rdCurY;
  logic busy, dropValid, violValid;
  logic [5:0] dropIdx, violIdx;

  int testsRun = 0;
  int testsFailed = 0;
  int dropCnt [64];
  int violCnt [64];
  int lastDrop = -1;
  bit orderBad = 0;

  always #2.5 clk = ~clk;

  streamWindowUpdater uut (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgDeadline(cfgDeadline), .cfgGap(cfgGap),
    .cfgX(cfgX), .cfgY(cfgY), .cfgDrop(cfgDrop),
    .svcValid(svcValid), .svcIdx(svcIdx),
    .tickValid(tickValid), .tickTime(tickTime),
    .rdIdx(rdIdx), .rdDeadline(rdDeadline), .rdCurX(rdCurX), .rdCurY(rdCurY),
    .busy(busy), .dropValid(dropValid), .dropIdx(dropIdx),
    .violValid(violValid), .violIdx(violIdx)
  );

  // Pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (dropValid) begin
      dropCnt[dropIdx] = dropCnt[dropIdx] + 1;
      if (int'(dropIdx) < lastDrop) orderBad = 1;
      lastDrop = int'(dropIdx);
    end
    if (violValid) violCnt[violIdx] = violCnt[violIdx] + 1;
  end

  task automatic check(string req, int got, int exp);
    testsRun++;
    if (got != exp) begin
      testsFailed++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic clearTally();
    for (int i = 0; i < 64; i++) begin
      dropCnt[i] = 0;
      violCnt[i] = 0;
    end
    lastDrop = -1;
    orderBad = 0;
  endtask

  task automatic cfgStream(int idx, int dl, int g, int x, int y, bit dr);
    @(negedge clk);
    cfgWe = 1; cfgIdx = 6'(idx); cfgDeadline = 16'(dl); cfgGap = 16'(g);
    cfgX = 5'(x); cfgY = 5'(y); cfgDrop = dr;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic service(int idx);
    @(negedge clk);
    svcValid = 1; svcIdx = 6'(idx);
    @(negedge clk);
    svcValid = 0;
  endtask

  task automatic tickPulse(int t);
    @(negedge clk);
    tickValid = 1; tickTime = 16'(t);
    @(negedge clk);
    tickValid = 0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic readState(int idx, output int dl, output int x, output int y);
    rdIdx = 6'(idx);
    #0.5;
    dl = int'(rdDeadline); x = int'(rdCurX); y = int'(rdCurY);
  endtask

  task automatic testReset();
    int dl, x, y;
    check("R1 busy", int'(busy), 0);
    check("R1 dropValid", int'(dropValid), 0);
    check("R1 violValid", int'(violValid), 0);
    readState(17, dl, x, y);
    check("R1 deadline", dl, 0);
    check("R1 curX", x, 0);
  endtask

  task automatic testConfig();
    int dl, x, y;
    cfgStream(3, 100, 10, 4, 6, 1);
    readState(3, dl, x, y);
    check("R2 deadline", dl, 100);
    check("R2 curX", x, 4);
    check("R2 curY", y, 6);
  endtask

  task automatic testService();
    int dl, x, y;
    cfgStream(5, 5000, 7, 0, 2, 0);
    service(5);
    readState(5, dl, x, y);
    check("R3 deadline after service", dl, 5007);
    check("R4 y shrinks", y, 1);
    service(5);
    readState(5, dl, x, y);
    check("R3 deadline second service", dl, 5014);
    check("R4 reload y", y, 2);
    check("R4 reload x", x, 0);
    cfgStream(4, 6000, 3, 2, 2, 0);
    service(4);
    readState(4, dl, x, y);
    check("R3 deadline stream4", dl, 6003);
    check("R4 y equal x unchanged", y, 2);
  endtask

  task automatic testMissLoop();
    int dl, x, y;
    clearTally();
    tickPulse(125);
    check("R10 busy after tick", int'(busy), 1);
    waitIdle();
    readState(3, dl, x, y);
    check("R6 deadline back in future", dl, 130);
    check("R7 curX after passes", x, 1);
    check("R7 curY after passes", y, 3);
    check("R9 drop count", dropCnt[3], 3);
    check("R8 no violation with x>0", violCnt[3], 0);
    check("R12 inactive stream no drop", dropCnt[60], 0);
    check("R12 inactive stream no violation", violCnt[60], 0);
  endtask

  task automatic testViolation();
    int dl, x, y;
    cfgStream(7, 120, 20, 0, 4, 0);
    clearTally();
    tickPulse(165);
    waitIdle();
    readState(7, dl, x, y);
    check("R8 violation count", violCnt[7], 3);
    check("R9 not droppable no drop", dropCnt[7], 0);
    check("R8 x unchanged", x, 0);
    check("R8 y unchanged", y, 4);
    check("R6 deadline stream7", dl, 180);
  endtask

  task automatic testWrap();
    int dl, x, y;
    cfgStream(9, 65530, 10, 5, 9, 1);
    cfgStream(10, 200, 10, 3, 5, 1);
    cfgStream(12, 5, 4, 3, 5, 1);
    clearTally();
    tickPulse(5);
    waitIdle();
    readState(9, dl, x, y);
    check("R5 wrap deadline", dl, 14);
    check("R5 wrap drops", dropCnt[9], 2);
    check("R7 wrap curX", x, 3);
    check("R7 wrap curY", y, 7);
    check("R5 future stream no drop", dropCnt[10], 0);
    check("R5 equal deadline not missed", dropCnt[12], 0);
  endtask

  task automatic testGapZero();
    int dl, x, y;
    cfgStream(11, 10, 0, 9, 9, 1);
    clearTally();
    tickPulse(12);
    waitIdle();
    readState(11, dl, x, y);
    check("R13 zero gap deadline", dl, 12);
    check("R13 zero gap passes", dropCnt[11], 2);
  endtask

  task automatic testOrder();
    int dl, x, y;
    clearTally();
    tickPulse(200);
    waitIdle();
    check("R10 drops in index order", int'(orderBad), 0);
    readState(9, dl, x, y);
    check("R6 many passes deadline", dl, 204);
    check("R6 many passes drops", dropCnt[9], 19);
    check("R10 last drop index", lastDrop, 12);
    check("R10 busy low after scan", int'(busy), 0);
  endtask

  task automatic testTickWhileBusy();
    int dl, x, y;
    clearTally();
    tickPulse(220);
    tickPulse(290);
    waitIdle();
    readState(9, dl, x, y);
    check("R11 second tick ignored", dl, 224);
  endtask

  task automatic testPriority();
    int dl, x, y;
    tickPulse(240);
    service(4);
    waitIdle();
    readState(4, dl, x, y);
    check("R12 service during scan", dl, 6006);
    readState(9, dl, x, y);
    check("R12 scan still completes", dl, 244);
  endtask

  initial begin
    #750000;
    testsFailed++;
    testsRun++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    clearTally();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testConfig();
    testService();
    testMissLoop();
    testViolation();
    testWrap();
    testGapZero();
    testOrder();
    testTickWhileBusy();
    testPriority();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule